// File: doc/BRIEF.md
# Mispredict Squash Controller

This block decides which in-flight instructions must be cancelled when a branch in the last execute stage of a six-stage in-order pipeline turns out to be mispredicted. The pipeline has `WIDTH` slots per stage, so it can be scalar (`WIDTH=1`) or superscalar. The stages are fetch, decode, issue, execute-0, execute-1 and writeback. The pipeline presents a valid bit for every slot in the five stages up to execute-1. When execute-1 resolves a branch, it raises a resolve strobe that carries the branch's slot within its group, a mispredict flag and a delay-slot enable.

Within a stage, slot 0 is the oldest. A later stage holds older instructions than an earlier one. Every valid instruction younger than the branch is killed: the slots behind it in execute-1 and everything in execute-0, issue, decode and fetch. When delay-slot mode is on, the first valid instruction after the branch in that age order is spared, wherever it sits. If no younger instruction has been fetched yet (for example after an instruction-cache miss), a registered pending flag tells fetch to keep the next instruction it accepts.

The kill mask and the kill count are combinational from the strobe, so they can gate the stage registers on the same edge.

Top module: `sq_kill_ctl`

## Requirements
- R1: Without a strobe that is both valid and mispredicted, `kill_mask` is all zero and `kill_count` is 0.
- R2: On a mispredict, a valid slot is killed when it is behind the branch slot in execute-1 (higher slot index) or sits anywhere in execute-0, issue, decode or fetch. The branch slot and the older execute-1 slots are never killed. In `stage_vld` and `kill_mask`, stage s (0=fetch, 1=decode, 2=issue, 3=execute-0, 4=execute-1) occupies bits [s*WIDTH +: WIDTH], and bit j of that field is slot j.
- R3: An invalid slot is never killed and never counted.
- R4: With `dslot_en` high, exactly one valid younger slot is spared: the first one found in this age order. The order is execute-1 slots above the branch, then execute-0 slots 0 to WIDTH-1, then issue, then decode, then fetch.
- R5: `kill_count` equals the number of set bits in `kill_mask`. For a full 3-wide pipeline it is 14 (branch in slot 0, no delay slot), 13 (slot 0, delay slot), 12 (slot 2, no delay slot) and 11 (slot 2, delay slot).
- R6: After a mispredict with `dslot_en` high and no valid younger slot, `dslot_pending` is 1 from the next clock edge onward.
- R7: `dslot_pending` clears on the clock edge after `fetch_accept` is high. When a new setting condition occurs in the same cycle as `fetch_accept`, the set wins. A mispredict with `dslot_en` low never sets the flag.
- R8: Synchronous reset clears `dslot_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_vld | input | 5*WIDTH | Per-slot valid bits, fetch in the low field and execute-1 in the high field |
| rslv_valid | input | 1 | A branch resolves in execute-1 this cycle |
| rslv_mispredict | input | 1 | The resolving branch was mispredicted |
| rslv_slot | input | SLOT_W | Slot of the branch within its execute-1 group |
| dslot_en | input | 1 | Delay-slot mode on |
| fetch_accept | input | 1 | Fetch accepts the next instruction; consumes a pending delay slot |
| kill_mask | output | 5*WIDTH | Per-slot kill bits, same layout as stage_vld |
| kill_count | output | CNT_W | Number of killed instructions |
| dslot_pending | output | 1 | Delay slot not yet fetched; keep the next fetched instruction |

## Verification
The hardest case to reach is a delay slot that sits far from the branch. This happens when execute-1 has no younger slot and the delay slot has drifted past bubbles into issue or fetch, or when nothing younger has been fetched at all. The stimulus builds these cases directly with sparse valid patterns: an execute-0 bubble, a lone fetch slot, and an empty pipeline behind the branch. It then follows the empty case with sequences that set, hold and clear the pending flag, including a set that coincides with an accept.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int NSTG = 5;
  typedef enum int unsigned {
    STG_F  = 0,
    STG_D  = 1,
    STG_I  = 2,
    STG_X0 = 3,
    STG_X1 = 4
  } stage_e;
endpackage

// File: rtl/sq_age_view.sv
// Reorders the slot valids into age order (execute-1 first) and keeps only
// those younger than the resolving branch.
module sq_age_view
  import sq_pkg::*;
#(
  parameter int WIDTH  = 3,
  parameter int SLOT_W = 2
) (
  input  logic [NSTG*WIDTH-1:0] stage_vld,
  input  logic [SLOT_W-1:0]     br_slot,
  output logic [NSTG*WIDTH-1:0] younger_age
);
  for (genvar a = 0; a < NSTG; a++) begin : g_age
    localparam int S = NSTG - 1 - a;
    for (genvar j = 0; j < WIDTH; j++) begin : g_slot
      if (S == int'(STG_X1)) begin : g_res
        assign younger_age[a*WIDTH+j] = stage_vld[S*WIDTH+j] & (SLOT_W'(j) > br_slot);
      end else begin : g_old
        assign younger_age[a*WIDTH+j] = stage_vld[S*WIDTH+j];
      end
    end
  end
endmodule

// File: rtl/sq_first_pick.sv
// One-hot of the lowest set bit.
module sq_first_pick #(
  parameter int N = 15
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar k = 0; k < N; k++) begin : g_chain
    assign pick[k]   = req[k] & ~seen[k];
    assign seen[k+1] = seen[k] | req[k];
  end
  assign any = seen[N];
endmodule

// File: rtl/sq_popcount.sv
module sq_popcount #(
  parameter int N   = 15,
  parameter int C_W = 4
) (
  input  logic [N-1:0]   bits,
  output logic [C_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < N; k++) count = count + C_W'(bits[k]);
  end
endmodule

// File: rtl/sq_kill_ctl.sv
module sq_kill_ctl
  import sq_pkg::*;
#(
  parameter int WIDTH = 3,
  localparam int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int NSLOT  = NSTG * WIDTH,
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLOT-1:0]  stage_vld,
  input  logic              rslv_valid,
  input  logic              rslv_mispredict,
  input  logic [SLOT_W-1:0] rslv_slot,
  input  logic              dslot_en,
  input  logic              fetch_accept,
  output logic [NSLOT-1:0]  kill_mask,
  output logic [CNT_W-1:0]  kill_count,
  output logic              dslot_pending
);
  logic             fire;
  logic [NSLOT-1:0] younger_age, spare_age, kill_age;
  logic             any_younger;

  assign fire = rslv_valid & rslv_mispredict;

  sq_age_view #(.WIDTH(WIDTH), .SLOT_W(SLOT_W)) u_age (
    .stage_vld  (stage_vld),
    .br_slot    (rslv_slot),
    .younger_age(younger_age)
  );

  sq_first_pick #(.N(NSLOT)) u_pick (
    .req (younger_age),
    .pick(spare_age),
    .any (any_younger)
  );

  assign kill_age = fire ? (younger_age & ~(dslot_en ? spare_age : '0)) : '0;

  // back from age order to port order
  for (genvar a = 0; a < NSTG; a++) begin : g_back
    assign kill_mask[(NSTG-1-a)*WIDTH +: WIDTH] = kill_age[a*WIDTH +: WIDTH];
  end

  sq_popcount #(.N(NSLOT), .C_W(CNT_W)) u_cnt (
    .bits (kill_mask),
    .count(kill_count)
  );

  always_ff @(posedge clk) begin
    if (rst)                                   dslot_pending <= 1'b0;
    else if (fire && dslot_en && !any_younger) dslot_pending <= 1'b1;
    else if (fetch_accept)                     dslot_pending <= 1'b0;
  end
endmodule

// File: rtl/sq_kill_chk.sv
module sq_kill_chk
  import sq_pkg::*;
#(
  parameter int WIDTH = 3,
  localparam int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam int NSLOT  = NSTG * WIDTH,
  localparam int CNT_W  = $clog2(NSLOT + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [NSLOT-1:0]  stage_vld,
  input logic              rslv_valid,
  input logic              rslv_mispredict,
  input logic [SLOT_W-1:0] rslv_slot,
  input logic              dslot_en,
  input logic              fetch_accept,
  input logic [NSLOT-1:0]  kill_mask,
  input logic [CNT_W-1:0]  kill_count,
  input logic              dslot_pending
);
  logic [WIDTH-1:0] x1_old;
  always_comb
    for (int j = 0; j < WIDTH; j++) x1_old[j] = (SLOT_W'(j) <= rslv_slot);

  a_r1_idle_no_kill: assert property (@(posedge clk) disable iff (rst)
    !(rslv_valid && rslv_mispredict) |-> (kill_mask == '0 && kill_count == '0));

  a_r2_older_kept: assert property (@(posedge clk) disable iff (rst)
    (kill_mask[STG_X1*WIDTH +: WIDTH] & x1_old) == '0);

  a_r3_only_valid: assert property (@(posedge clk) disable iff (rst)
    (kill_mask & ~stage_vld) == '0);

  a_r5_count_match: assert property (@(posedge clk) disable iff (rst)
    kill_count == CNT_W'($countones(kill_mask)));

  a_r6_pending_set: assert property (@(posedge clk) disable iff (rst)
    (rslv_valid && rslv_mispredict && dslot_en && stage_vld == '0) |=> dslot_pending);

  a_r7_pending_clear: assert property (@(posedge clk) disable iff (rst)
    (!(rslv_valid && rslv_mispredict) && fetch_accept) |=> !dslot_pending);

  a_r7_no_set_without_ds: assert property (@(posedge clk) disable iff (rst)
    (!dslot_pending && !(rslv_valid && rslv_mispredict && dslot_en)) |=> !dslot_pending);
endmodule

bind sq_kill_ctl sq_kill_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .stage_vld(stage_vld), .rslv_valid(rslv_valid),
  .rslv_mispredict(rslv_mispredict), .rslv_slot(rslv_slot), .dslot_en(dslot_en),
  .fetch_accept(fetch_accept), .kill_mask(kill_mask), .kill_count(kill_count),
  .dslot_pending(dslot_pending)
);

// File: tb/sim_sq_kill_ctl.sv
module sim_sq_kill_ctl;
  localparam int CLK_PER = 10;
  localparam int W = 3;
  localparam int N = 15;
  localparam int CW = 4;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  stage_vld = '0;
  logic          rslv_valid = 1'b0, rslv_mispredict = 1'b0, dslot_en = 1'b0;
  logic [1:0]    rslv_slot = '0;
  logic          fetch_accept = 1'b0;
  logic [N-1:0]  kill_mask;
  logic [CW-1:0] kill_count;
  logic          dslot_pending;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  sq_kill_ctl #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .stage_vld(stage_vld), .rslv_valid(rslv_valid),
    .rslv_mispredict(rslv_mispredict), .rslv_slot(rslv_slot), .dslot_en(dslot_en),
    .fetch_accept(fetch_accept), .kill_mask(kill_mask), .kill_count(kill_count),
    .dslot_pending(dslot_pending)
  );

  // {vld, valid, mispredict, slot, ds, exp_mask, exp_cnt}, 39 bits
  localparam logic [38:0] VEC [NV] = '{
    {15'h7FFF, 1'b1, 1'b1, 2'd0, 1'b0, 15'h6FFF, 4'd14}, // R2 R5 slot0 no ds
    {15'h7FFF, 1'b1, 1'b1, 2'd0, 1'b1, 15'h4FFF, 4'd13}, // R4 R5 slot0 ds
    {15'h7FFF, 1'b1, 1'b1, 2'd2, 1'b0, 15'h0FFF, 4'd12}, // R5 slot2 no ds
    {15'h7FFF, 1'b1, 1'b1, 2'd2, 1'b1, 15'h0DFF, 4'd11}, // R4 R5 spare in X0
    {15'h7FFF, 1'b0, 1'b1, 2'd0, 1'b0, 15'h0000, 4'd0},  // R1 no strobe
    {15'h7FFF, 1'b1, 1'b0, 2'd0, 1'b0, 15'h0000, 4'd0},  // R1 predicted right
    {15'h1249, 1'b1, 1'b1, 2'd0, 1'b1, 15'h0049, 4'd3},  // R4 scalar-like
    {15'h1049, 1'b1, 1'b1, 2'd0, 1'b1, 15'h0009, 4'd2},  // R4 X0 bubble
    {15'h1001, 1'b1, 1'b1, 2'd0, 1'b1, 15'h0000, 4'd0},  // R4 spare in F
    {15'h1001, 1'b1, 1'b1, 2'd0, 1'b0, 15'h0001, 4'd1},  // R2 lone F
    {15'h7400, 1'b1, 1'b1, 2'd1, 1'b1, 15'h0400, 4'd1},  // R4 spare X1 slot2
    {15'h3108, 1'b1, 1'b1, 2'd1, 1'b1, 15'h0008, 4'd1},  // R4 spare in I
    {15'h5555, 1'b1, 1'b1, 2'd1, 1'b0, 15'h4555, 4'd7}   // R3 bubbles
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] v, input logic rv, input logic mp,
                       input logic [1:0] sl, input logic ds, input logic fa);
    stage_vld = v; rslv_valid = rv; rslv_mispredict = mp;
    rslv_slot = sl; dslot_en = ds; fetch_accept = fa;
  endtask

  initial begin
    #(CLK_PER * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 pending after reset", 32'(dslot_pending), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][38:24], VEC[i][23], VEC[i][22], VEC[i][21:20], VEC[i][19], 1'b0);
      #1;
      chk("R1-R5 vec mask", 32'(kill_mask), 32'(VEC[i][18:4]));
      chk("R5 vec count", 32'(kill_count), 32'(VEC[i][3:0]));
      @(negedge clk);
    end
    // no vector above has an empty younger set with ds on, so flag stays clear
    chk("R7 no spurious pending", 32'(dslot_pending), 32'd0);

    // R7: empty younger set with ds off does not set the flag
    drive(15'h1000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 ds off no pending", 32'(dslot_pending), 32'd0);

    // R6: set
    drive(15'h1000, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0);
    #1 chk("R6 no kill when empty", 32'(kill_count), 32'd0);
    @(negedge clk);
    chk("R6 pending set", 32'(dslot_pending), 32'd1);
    drive('0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R6 pending held", 32'(dslot_pending), 32'd1);
    drive('0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 pending cleared", 32'(dslot_pending), 32'd0);

    // R7: set wins over accept
    drive(15'h3000, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 set beats accept", 32'(dslot_pending), 32'd1);

    // R8: reset clears
    drive('0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears pending", 32'(dslot_pending), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule